// File: doc/BRIEF.md
# Segment Table Translation Unit

This block turns a logical address, given as a segment number and an offset, into a physical address. It does so with a segment table held in local registers. Every table entry holds a base physical address, a segment length, a validity flag and three privilege bits for read, write and execute. A request also carries an access type. The block runs four protection checks on it and returns either base plus offset or a fault with a cause code.

Before any table entry is looked at, the segment number is compared with a length register. That register holds how many segments the current context uses. Software reloads the entries and the length register through a simple register write port when it switches context. Each request produces exactly one response, one clock cycle later.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset all response outputs are zero, the length register is 0 and every entry is invalid, so any request faults with cause 1.
- R2: A request accepted in one cycle yields a response with `rsp_valid` high in the next cycle only. Without a request `rsp_valid` stays low.
- R3: A segment number greater than or equal to the length register faults with cause 1, even when that entry is programmed valid. This check is applied before any other.
- R4: An entry whose valid flag is 0 faults with cause 2. This cause takes priority over the limit and permission checks.
- R5: An offset greater than or equal to the entry limit faults with cause 3, and this takes priority over the permission check. An offset of limit-1 passes. A limit of 0 rejects every offset, and a limit of 65536 admits every offset.
- R6: The privilege bits are bit 0 read, bit 1 write and bit 2 execute. The access codes are 0 for read, 1 for write and 2 for execute, and code 3 is never permitted. An access whose privilege bit is clear faults with cause 4.
- R7: A request that passes all checks returns cause 0 with `rsp_pa` = (base + offset) modulo 2^24.
- R8: On a fault `rsp_pa` is zero, and `rsp_fault` is high only in that response cycle.
- R9: A write to an entry or to the length register affects requests from the next cycle on. A request in the same cycle as the write is translated with the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for one table entry |
| cfg_idx | input | 4 | Entry index being written |
| cfg_base | input | 24 | Base physical address for the entry |
| cfg_limit | input | 17 | Segment length in bytes (0 to 65536) |
| cfg_valid | input | 1 | Valid flag for the entry |
| cfg_perm | input | 3 | Privileges: bit0 read, bit1 write, bit2 execute |
| len_we | input | 1 | Write strobe for the length register |
| len_val | input | 5 | Number of segments in use (0 to 16) |
| req_valid | input | 1 | Translation request strobe |
| req_seg | input | 4 | Segment number |
| req_off | input | 16 | Offset within the segment |
| req_acc | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 reserved |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_pa | output | 24 | Physical address, zero on fault |
| rsp_fault | output | 1 | Fault pulse |
| rsp_cause | output | 3 | 0 none, 1 length, 2 invalid, 3 limit, 4 permission |

## Verification
The bench works on the check order. An invalid entry is requested with an offset past its limit, and an over-limit offset is requested with a forbidden access. A design with its priorities swapped would report the wrong cause in these cases. The entry programmed valid but beyond the length register would be translated by a design that reads the table before comparing the length. Offsets at limit-1 and at the limit catch an off-by-one compare, and a base near the top of the space checks that the sum wraps at 24 bits. The bench also writes an entry in the same cycle as a request to it. A design that forwarded the new contents would return the new base where the old one is expected.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef enum logic [2:0] {
    CAUSE_NONE  = 3'd0,
    CAUSE_LEN   = 3'd1,
    CAUSE_INVAL = 3'd2,
    CAUSE_LIMIT = 3'd3,
    CAUSE_PERM  = 3'd4
  } cause_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  localparam int PERM_W = 3;
  localparam int PERM_R = 0;
  localparam int PERM_WR = 1;
  localparam int PERM_X = 2;

endpackage

// File: rtl/seg_table_regs.sv
module seg_table_regs
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W  = 4,
  parameter int BASE_W = 24,
  parameter int LIM_W  = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEG_W-1:0]  wr_idx,
  input  logic [BASE_W-1:0] wr_base,
  input  logic [LIM_W-1:0]  wr_limit,
  input  logic              wr_valid,
  input  logic [PERM_W-1:0] wr_perm,
  input  logic              len_wr,
  input  logic [SEG_W:0]    len_wdata,
  input  logic [SEG_W-1:0]  rd_idx,
  output logic [BASE_W-1:0] rd_base,
  output logic [LIM_W-1:0]  rd_limit,
  output logic              rd_valid,
  output logic [PERM_W-1:0] rd_perm,
  output logic [SEG_W:0]    len_q
);

  localparam int NSEG = 1 << SEG_W;

  logic [BASE_W-1:0] base_q  [NSEG];
  logic [LIM_W-1:0]  limit_q [NSEG];
  logic              valid_q [NSEG];
  logic [PERM_W-1:0] perm_q  [NSEG];

  for (genvar g = 0; g < NSEG; g++) begin : g_ent
    logic sel;
    assign sel = wr_en && (wr_idx == SEG_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[g]  <= '0;
        limit_q[g] <= '0;
        valid_q[g] <= 1'b0;
        perm_q[g]  <= '0;
      end else if (sel) begin
        base_q[g]  <= wr_base;
        limit_q[g] <= wr_limit;
        valid_q[g] <= wr_valid;
        perm_q[g]  <= wr_perm;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      len_q <= '0;
    else if (len_wr) len_q <= len_wdata;
  end

  // Reads see the registered contents, so a same-cycle write is not forwarded.
  assign rd_base  = base_q[rd_idx];
  assign rd_limit = limit_q[rd_idx];
  assign rd_valid = valid_q[rd_idx];
  assign rd_perm  = perm_q[rd_idx];

  // R1
  reset_len_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (len_q == '0));

endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W  = 4,
  parameter int OFF_W  = 16,
  parameter int BASE_W = 24,
  parameter int LIM_W  = 17
) (
  input  logic [SEG_W-1:0]  seg,
  input  logic [OFF_W-1:0]  off,
  input  logic [1:0]        acc,
  input  logic [SEG_W:0]    len,
  input  logic [BASE_W-1:0] base,
  input  logic [LIM_W-1:0]  limit,
  input  logic              ent_valid,
  input  logic [PERM_W-1:0] perm,
  output cause_e            cause,
  output logic [BASE_W-1:0] pa,
  output logic              len_bad,
  output logic              inval_bad,
  output logic              limit_bad,
  output logic              perm_bad
);

  function automatic logic seg_in_range(input logic [SEG_W-1:0] s,
                                        input logic [SEG_W:0] n);
    return {1'b0, s} < n;
  endfunction

  function automatic logic off_in_limit(input logic [OFF_W-1:0] o,
                                        input logic [LIM_W-1:0] l);
    return LIM_W'(o) < l;
  endfunction

  function automatic logic access_allowed(input logic [PERM_W-1:0] p,
                                          input logic [1:0] a);
    case (acc_e'(a))
      ACC_READ:  return p[PERM_R];
      ACC_WRITE: return p[PERM_WR];
      ACC_EXEC:  return p[PERM_X];
      default:   return 1'b0;
    endcase
  endfunction

  function automatic logic [BASE_W-1:0] phys_sum(input logic [BASE_W-1:0] b,
                                                 input logic [OFF_W-1:0] o);
    return b + BASE_W'(o);
  endfunction

  assign len_bad   = !seg_in_range(seg, len);
  assign inval_bad = !ent_valid;
  assign limit_bad = !off_in_limit(off, limit);
  assign perm_bad  = !access_allowed(perm, acc);

  always_comb begin
    if (len_bad)        cause = CAUSE_LEN;
    else if (inval_bad) cause = CAUSE_INVAL;
    else if (limit_bad) cause = CAUSE_LIMIT;
    else if (perm_bad)  cause = CAUSE_PERM;
    else                cause = CAUSE_NONE;
  end

  assign pa = (cause == CAUSE_NONE) ? phys_sum(base, off) : '0;

  // R3 R4 R5 R6
  always_comb begin
    cause_order_chk: assert ((cause == CAUSE_NONE) ==
                             !(len_bad || inval_bad || limit_bad || perm_bad));
  end

endmodule

// File: rtl/seg_rsp_reg.sv
module seg_rsp_reg
  import seg_xlate_pkg::*;
#(
  parameter int BASE_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  cause_e            in_cause,
  input  logic [BASE_W-1:0] in_pa,
  output logic              out_valid,
  output logic              out_fault,
  output logic [2:0]        out_cause,
  output logic [BASE_W-1:0] out_pa
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_fault <= 1'b0;
      out_cause <= '0;
      out_pa    <= '0;
    end else begin
      out_valid <= in_valid;
      out_fault <= in_valid && (in_cause != CAUSE_NONE);
      out_cause <= in_valid ? in_cause : CAUSE_NONE;
      out_pa    <= (in_valid && in_cause == CAUSE_NONE) ? in_pa : '0;
    end
  end

  // R8
  fault_pa_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_fault |-> (out_pa == '0));

  // R8
  fault_in_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_fault |-> out_valid);

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W  = 4,
  parameter int OFF_W  = 16,
  parameter int BASE_W = 24,
  localparam int LIM_W = OFF_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SEG_W-1:0]  cfg_idx,
  input  logic [BASE_W-1:0] cfg_base,
  input  logic [LIM_W-1:0]  cfg_limit,
  input  logic              cfg_valid,
  input  logic [2:0]        cfg_perm,
  input  logic              len_we,
  input  logic [SEG_W:0]    len_val,
  input  logic              req_valid,
  input  logic [SEG_W-1:0]  req_seg,
  input  logic [OFF_W-1:0]  req_off,
  input  logic [1:0]        req_acc,
  output logic              rsp_valid,
  output logic [BASE_W-1:0] rsp_pa,
  output logic              rsp_fault,
  output logic [2:0]        rsp_cause
);

  logic [BASE_W-1:0] ent_base;
  logic [LIM_W-1:0]  ent_limit;
  logic              ent_valid;
  logic [PERM_W-1:0] ent_perm;
  logic [SEG_W:0]    len_q;
  cause_e            chk_cause;
  logic [BASE_W-1:0] chk_pa;
  logic              len_bad, inval_bad, limit_bad, perm_bad;

  seg_table_regs #(.SEG_W(SEG_W), .BASE_W(BASE_W), .LIM_W(LIM_W)) u_tab (
    .clk, .rst_n,
    .wr_en(cfg_we), .wr_idx(cfg_idx), .wr_base(cfg_base), .wr_limit(cfg_limit),
    .wr_valid(cfg_valid), .wr_perm(cfg_perm),
    .len_wr(len_we), .len_wdata(len_val),
    .rd_idx(req_seg), .rd_base(ent_base), .rd_limit(ent_limit),
    .rd_valid(ent_valid), .rd_perm(ent_perm), .len_q(len_q)
  );

  seg_check #(.SEG_W(SEG_W), .OFF_W(OFF_W), .BASE_W(BASE_W), .LIM_W(LIM_W)) u_chk (
    .seg(req_seg), .off(req_off), .acc(req_acc), .len(len_q),
    .base(ent_base), .limit(ent_limit), .ent_valid(ent_valid), .perm(ent_perm),
    .cause(chk_cause), .pa(chk_pa),
    .len_bad(len_bad), .inval_bad(inval_bad), .limit_bad(limit_bad), .perm_bad(perm_bad)
  );

  seg_rsp_reg #(.BASE_W(BASE_W)) u_rsp (
    .clk, .rst_n,
    .in_valid(req_valid), .in_cause(chk_cause), .in_pa(chk_pa),
    .out_valid(rsp_valid), .out_fault(rsp_fault), .out_cause(rsp_cause), .out_pa(rsp_pa)
  );

  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R2
  no_req_no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R3
  len_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ({1'b0, req_seg} >= len_q)) |=> (rsp_fault && rsp_cause == 3'd1));

  // R4
  inval_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !len_bad && !ent_valid) |=> (rsp_cause == 3'd2));

  // R8
  cause_iff_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_fault == (rsp_cause != 3'd0)));

endmodule

// File: tb/tb_seg_xlate_unit.sv
`timescale 1ns/1ps
module tb_seg_xlate_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_idx = '0;
  logic [23:0] cfg_base = '0;
  logic [16:0] cfg_limit = '0;
  logic        cfg_valid = 1'b0;
  logic [2:0]  cfg_perm = '0;
  logic        len_we = 1'b0;
  logic [4:0]  len_val = '0;
  logic        req_valid = 1'b0;
  logic [3:0]  req_seg = '0;
  logic [15:0] req_off = '0;
  logic [1:0]  req_acc = '0;
  logic        rsp_valid;
  logic [23:0] rsp_pa;
  logic        rsp_fault;
  logic [2:0]  rsp_cause;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  seg_xlate_unit dut (.*);

  typedef struct packed {
    logic [3:0]  seg;
    logic [15:0] off;
    logic [1:0]  acc;
    logic [2:0]  cause;
    logic [23:0] pa;
    logic [7:0]  tag;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{4'd0, 16'h0000, 2'd0, 3'd0, 24'h010000, 8'd7},
    '{4'd0, 16'h0FFF, 2'd1, 3'd0, 24'h010FFF, 8'd5},
    '{4'd0, 16'h1000, 2'd0, 3'd3, 24'h000000, 8'd5},
    '{4'd1, 16'h0010, 2'd0, 3'd0, 24'h200010, 8'd7},
    '{4'd1, 16'h0010, 2'd1, 3'd4, 24'h000000, 8'd6},
    '{4'd1, 16'h0010, 2'd2, 3'd4, 24'h000000, 8'd6},
    '{4'd2, 16'hFFFF, 2'd1, 3'd0, 24'h3FFFFF, 8'd5},
    '{4'd2, 16'h0000, 2'd0, 3'd4, 24'h000000, 8'd6},
    '{4'd3, 16'h0000, 2'd0, 3'd2, 24'h000000, 8'd4},
    '{4'd3, 16'h0200, 2'd1, 3'd2, 24'h000000, 8'd4},
    '{4'd4, 16'h01FF, 2'd2, 3'd0, 24'h0000FF, 8'd7},
    '{4'd4, 16'h0200, 2'd0, 3'd3, 24'h000000, 8'd5},
    '{4'd5, 16'h0000, 2'd0, 3'd3, 24'h000000, 8'd5},
    '{4'd6, 16'h0000, 2'd0, 3'd1, 24'h000000, 8'd3},
    '{4'd7, 16'h0000, 2'd0, 3'd1, 24'h000000, 8'd3},
    '{4'd0, 16'h0000, 2'd3, 3'd4, 24'h000000, 8'd6},
    '{4'd1, 16'h0100, 2'd1, 3'd3, 24'h000000, 8'd5}
  };

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr_ent(input logic [3:0] i, input logic [23:0] b,
                        input logic [16:0] l, input logic v, input logic [2:0] p);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = i; cfg_base = b; cfg_limit = l; cfg_valid = v; cfg_perm = p;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wr_len(input logic [4:0] n);
    @(negedge clk);
    len_we = 1'b1; len_val = n;
    @(negedge clk);
    len_we = 1'b0;
  endtask

  // Request, sample the response a cycle later, then check the fault has ended.
  task automatic xlate(input logic [3:0] s, input logic [15:0] o, input logic [1:0] a,
                       input logic [2:0] ec, input logic [23:0] ep, input string req);
    @(negedge clk);
    req_valid = 1'b1; req_seg = s; req_off = o; req_acc = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid == 1'b1, "R2", "rsp_valid", 32'(rsp_valid), 32'd1);
    chk(rsp_cause == ec, req, "cause", 32'(rsp_cause), 32'(ec));
    chk(rsp_fault == (ec != 3'd0), "R8", "fault", 32'(rsp_fault), 32'(ec != 3'd0));
    chk(rsp_pa == ep, (ec == 3'd0) ? "R7" : "R8", "pa", 32'(rsp_pa), 32'(ep));
    @(negedge clk);
    chk(!rsp_valid && !rsp_fault, "R8", "pulse end", 32'({rsp_valid, rsp_fault}), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(!rsp_valid && !rsp_fault && rsp_cause == 0 && rsp_pa == 0, "R1", "reset outputs",
        32'({rsp_valid, rsp_fault, rsp_cause}), 32'd0);
    rst_n = 1'b1;
    // R1: length 0 makes every request a length fault
    xlate(4'd0, 16'h0, 2'd0, 3'd1, 24'h0, "R1");

    wr_ent(4'd0, 24'h010000, 17'h01000, 1'b1, 3'b111);
    wr_ent(4'd1, 24'h200000, 17'h00100, 1'b1, 3'b001);
    wr_ent(4'd2, 24'h3F0000, 17'h10000, 1'b1, 3'b010);
    wr_ent(4'd3, 24'h050000, 17'h00100, 1'b0, 3'b111);
    wr_ent(4'd4, 24'hFFFF00, 17'h00200, 1'b1, 3'b100);
    wr_ent(4'd5, 24'h123456, 17'h00000, 1'b1, 3'b111);
    wr_ent(4'd7, 24'h777000, 17'h08000, 1'b1, 3'b111);
    wr_len(5'd6);

    // Vector table: R3 length, R4 invalid, R5 limit, R6 permission, R7 sum
    for (int i = 0; i < NV; i++)
      xlate(VECS[i].seg, VECS[i].off, VECS[i].acc, VECS[i].cause, VECS[i].pa,
            $sformatf("R%0d", VECS[i].tag));

    // R2: back-to-back requests each answered one cycle later
    @(negedge clk);
    req_valid = 1'b1; req_seg = 4'd0; req_off = 16'h0020; req_acc = 2'd0;
    @(negedge clk);
    chk(rsp_valid && rsp_pa == 24'h010020, "R2", "b2b first", 32'(rsp_pa), 32'h010020);
    req_seg = 4'd1; req_off = 16'h0001;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid && rsp_pa == 24'h200001, "R2", "b2b second", 32'(rsp_pa), 32'h200001);
    @(negedge clk);
    chk(!rsp_valid, "R2", "idle after b2b", 32'(rsp_valid), 32'd0);

    // R9: same-cycle entry write sees old base, next request sees new one
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 4'd0; cfg_base = 24'h0A0000; cfg_limit = 17'h01000;
    cfg_valid = 1'b1; cfg_perm = 3'b111;
    req_valid = 1'b1; req_seg = 4'd0; req_off = 16'h0004; req_acc = 2'd0;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    chk(rsp_pa == 24'h010004, "R9", "old entry", 32'(rsp_pa), 32'h010004);
    xlate(4'd0, 16'h0004, 2'd0, 3'd0, 24'h0A0004, "R9");

    // R9: same-cycle length write, then full 16-entry length admits segment 15
    wr_ent(4'd15, 24'h400000, 17'h00010, 1'b1, 3'b001);
    @(negedge clk);
    len_we = 1'b1; len_val = 5'd16;
    req_valid = 1'b1; req_seg = 4'd15; req_off = 16'h0; req_acc = 2'd0;
    @(negedge clk);
    len_we = 1'b0; req_valid = 1'b0;
    chk(rsp_cause == 3'd1, "R9", "old length", 32'(rsp_cause), 32'd1);
    xlate(4'd15, 16'h000F, 2'd0, 3'd0, 24'h40000F, "R3");
    // R4: an entry turned invalid faults again
    wr_ent(4'd15, 24'h400000, 17'h00010, 1'b0, 3'b001);
    xlate(4'd15, 16'h0000, 2'd0, 3'd2, 24'h0, "R4");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule